// File: doc/BRIEF.md
# EEPROM Write-Completion Acknowledge Poller

This block runs on the controller side of a two-wire serial bus. It is started after a write to an EEPROM target. While the target copies its latched data into the array, it ignores its select code. The poller probes it repeatedly until it answers, and each probe is a START primitive, the select byte and one acknowledge sample. A missing acknowledge means the target is still busy, so the poller starts the next probe. It can optionally release the bus with a STOP first.

When the target acknowledges, the select byte just sent is already byte one of the next instruction. The poller therefore reports success without sending a STOP and without repeating the select byte, and the caller goes straight on with the rest of that instruction. If the target stays busy for a configured number of probes, the poller releases the bus with a STOP and reports a timeout.

The poller drives a simple primitive-level bus engine through a valid/ready command port. The engine reports the sampled acknowledge bit on the same cycle that it accepts an acknowledge-sample command.

Top module: `ackpoll_master`

## Requirements
- R1: During and immediately after reset, `bus_cmd_valid` and `poll_done` are 0 and `attempt_cnt` is 0.
- R2: A request (`poll_req`=1) is taken only while the poller is idle and `write_busy`=1. A request made while `write_busy`=0, or while a poll is running, issues no command and leaves `attempt_cnt` unchanged.
- R3: Each probe issues three commands in this order: START (`bus_cmd_op`=0), BYTE (`bus_cmd_op`=1) and ACK sample (`bus_cmd_op`=2). During BYTE, `bus_cmd_byte` is `{dev_sel, next_rw}`, captured when the request was taken. A command stays valid and unchanged until `bus_cmd_ready`=1.
- R4: If an ACK sample is accepted with `bus_ack`=0 and the limit has not been reached, the next command follows on the very next cycle. That command is START when `STOP_BETWEEN`=0, or STOP (`bus_cmd_op`=3) followed by START when `STOP_BETWEEN`=1.
- R5: If an ACK sample is accepted with `bus_ack`=1, then on the next cycle `poll_done`=1 with `poll_ok`=1. No further command is issued: no STOP and no repeated select byte.
- R6: `attempt_cnt` is cleared when a request is taken. It rises by one at each accepted ACK sample and holds its value after done until the next request is taken.
- R7: When the ACK sample of probe number `MAX_TRIES` is accepted with `bus_ack`=0, the poller issues STOP. On the cycle after that STOP is accepted, `poll_done`=1 with `poll_timeout`=1.
- R8: `poll_done` lasts exactly one cycle. While it is high, exactly one of `poll_ok` and `poll_timeout` is high. Both are 0 whenever `poll_done` is 0.
- R9: While a poll runs, a new command is presented on the cycle after the previous one is accepted, with no idle cycle in between. `bus_cmd_valid` is 0 whenever no poll is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_req | input | 1 | Request to start polling |
| write_busy | input | 1 | A target write cycle is known to be in progress |
| dev_sel | input | 7 | Target select code |
| next_rw | input | 1 | Direction bit of the following instruction |
| poll_done | output | 1 | One-cycle completion pulse |
| poll_ok | output | 1 | Target acknowledged (valid with `poll_done`) |
| poll_timeout | output | 1 | Attempt limit reached (valid with `poll_done`) |
| attempt_cnt | output | $clog2(MAX_TRIES+1) | Probes sampled in the current or last poll |
| bus_cmd_valid | output | 1 | Command presented to the bus engine |
| bus_cmd_op | output | 2 | 0 START, 1 BYTE, 2 ACK sample, 3 STOP |
| bus_cmd_byte | output | 8 | Byte to send for a BYTE command |
| bus_cmd_ready | input | 1 | Bus engine accepts the command |
| bus_ack | input | 1 | Sampled acknowledge (1 = acknowledged), valid on an accepted ACK sample |

## Verification
The target is modelled as busy for a chosen number of probes. The bench tries several counts:
- Zero probes gives a first-probe answer, which separates success from the retry path.
- A few probes exercises the retry loop.
- One fewer than the limit gives success on the final allowed probe, which distinguishes an off-by-one in the limit.
- More than the limit must yield STOP and a timeout.

A stalling ready pattern shows that commands are held until accepted. Requests made while no write is pending, and requests held high during a poll, must be ignored. A follow-up poll after a timeout shows that the counter restarts. Two instances, one per retry variant, distinguish a direct repeated START from STOP-then-START.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_ACK   = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SEL,
    ST_SAMPLE,
    ST_GAP_STOP,
    ST_END_STOP
  } seq_state_e;
endpackage

// File: rtl/ackpoll_try_ctr.sv
module ackpoll_try_ctr #(
  parameter int MAX_TRIES = 8,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             last_try
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_TRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  // True while the probe being sampled is the final one allowed
  assign last_try = (count == LAST_IDX);
endmodule

// File: rtl/ackpoll_sel_latch.sv
module ackpoll_sel_latch #(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] sel_in,
  input  logic              rw_in,
  output logic [BYTE_W-1:0] sel_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_byte <= '0;
    end else if (load) begin
      sel_byte <= {sel_in, rw_in};
    end
  end
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter bit STOP_BETWEEN = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    poll_req,
  input  logic    write_busy,
  input  logic    cmd_ready,
  input  logic    bus_ack,
  input  logic    last_try,
  output logic    load,
  output logic    try_inc,
  output logic    cmd_valid,
  output bus_op_e cmd_op,
  output logic    done,
  output logic    ok,
  output logic    timeout
);
  localparam bus_op_e RETRY_OP = STOP_BETWEEN ? OP_STOP : OP_START;
  localparam seq_state_e RETRY_ST = STOP_BETWEEN ? ST_GAP_STOP : ST_START;

  seq_state_e state;
  logic       xfer;

  assign xfer    = cmd_valid && cmd_ready;
  assign load    = (state == ST_IDLE) && poll_req && write_busy;
  assign try_inc = xfer && (state == ST_SAMPLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_START;
      done      <= 1'b0;
      ok        <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      done    <= 1'b0;
      ok      <= 1'b0;
      timeout <= 1'b0;
      if (state == ST_IDLE) begin
        if (load) begin
          state     <= ST_START;
          cmd_valid <= 1'b1;
          cmd_op    <= OP_START;
        end
      end else if (xfer) begin
        case (state)
          ST_START: begin
            state  <= ST_SEL;
            cmd_op <= OP_BYTE;
          end
          ST_SEL: begin
            state  <= ST_SAMPLE;
            cmd_op <= OP_ACK;
          end
          ST_SAMPLE: begin
            if (bus_ack) begin
              // Select byte already sent counts for the next instruction
              state     <= ST_IDLE;
              cmd_valid <= 1'b0;
              done      <= 1'b1;
              ok        <= 1'b1;
            end else if (last_try) begin
              state  <= ST_END_STOP;
              cmd_op <= OP_STOP;
            end else begin
              state  <= RETRY_ST;
              cmd_op <= RETRY_OP;
            end
          end
          ST_GAP_STOP: begin
            state  <= ST_START;
            cmd_op <= OP_START;
          end
          ST_END_STOP: begin
            state     <= ST_IDLE;
            cmd_valid <= 1'b0;
            done      <= 1'b1;
            timeout   <= 1'b1;
          end
          default: begin
            state     <= ST_IDLE;
            cmd_valid <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ackpoll_master.sv
module ackpoll_master
  import ackpoll_pkg::*;
#(
  parameter int MAX_TRIES    = 8,
  parameter bit STOP_BETWEEN = 1'b0,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             poll_req,
  input  logic             write_busy,
  input  logic [6:0]       dev_sel,
  input  logic             next_rw,
  output logic             poll_done,
  output logic             poll_ok,
  output logic             poll_timeout,
  output logic [CNT_W-1:0] attempt_cnt,
  output logic             bus_cmd_valid,
  output logic [1:0]       bus_cmd_op,
  output logic [7:0]       bus_cmd_byte,
  input  logic             bus_cmd_ready,
  input  logic             bus_ack
);
  logic    load;
  logic    try_inc;
  logic    last_try;
  bus_op_e op_q;

  ackpoll_try_ctr #(.MAX_TRIES(MAX_TRIES)) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (load),
    .inc      (try_inc),
    .count    (attempt_cnt),
    .last_try (last_try)
  );

  ackpoll_sel_latch #(.ADDR_W(7)) sel_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .sel_in   (dev_sel),
    .rw_in    (next_rw),
    .sel_byte (bus_cmd_byte)
  );

  ackpoll_seq #(.STOP_BETWEEN(STOP_BETWEEN)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .poll_req   (poll_req),
    .write_busy (write_busy),
    .cmd_ready  (bus_cmd_ready),
    .bus_ack    (bus_ack),
    .last_try   (last_try),
    .load       (load),
    .try_inc    (try_inc),
    .cmd_valid  (bus_cmd_valid),
    .cmd_op     (op_q),
    .done       (poll_done),
    .ok         (poll_ok),
    .timeout    (poll_timeout)
  );

  assign bus_cmd_op = op_q;
endmodule

// File: rtl/ackpoll_master_chk.sv
module ackpoll_master_chk #(
  parameter int MAX_TRIES    = 8,
  parameter bit STOP_BETWEEN = 1'b0,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             poll_req,
  input logic             write_busy,
  input logic [6:0]       dev_sel,
  input logic             next_rw,
  input logic             poll_done,
  input logic             poll_ok,
  input logic             poll_timeout,
  input logic [CNT_W-1:0] attempt_cnt,
  input logic             bus_cmd_valid,
  input logic [1:0]       bus_cmd_op,
  input logic [7:0]       bus_cmd_byte,
  input logic             bus_cmd_ready,
  input logic             bus_ack
);
  logic acc;
  assign acc = bus_cmd_valid && bus_cmd_ready;

  p_hold_until_taken_r3: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid && !bus_cmd_ready |=> bus_cmd_valid && $stable(bus_cmd_op) && $stable(bus_cmd_byte));

  p_byte_after_start_r3: assert property (@(posedge clk) disable iff (rst)
    acc && bus_cmd_op == 2'd0 |=> bus_cmd_valid && bus_cmd_op == 2'd1);

  p_sample_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
    acc && bus_cmd_op == 2'd1 |=> bus_cmd_valid && bus_cmd_op == 2'd2);

  p_retry_follows_r4: assert property (@(posedge clk) disable iff (rst)
    acc && bus_cmd_op == 2'd2 && !bus_ack |=> bus_cmd_valid && (bus_cmd_op == 2'd0 || bus_cmd_op == 2'd3));

  p_ack_finishes_r5: assert property (@(posedge clk) disable iff (rst)
    acc && bus_cmd_op == 2'd2 && bus_ack |=> poll_done && poll_ok && !bus_cmd_valid);

  p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    attempt_cnt <= CNT_W'(MAX_TRIES));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    acc && bus_cmd_op == 2'd2 |=> attempt_cnt == $past(attempt_cnt) + 1'b1);

  p_limit_stop_r7: assert property (@(posedge clk) disable iff (rst)
    acc && bus_cmd_op == 2'd2 && !bus_ack && attempt_cnt == CNT_W'(MAX_TRIES - 1)
    |=> bus_cmd_valid && bus_cmd_op == 2'd3);

  p_timeout_after_stop_r7: assert property (@(posedge clk) disable iff (rst)
    poll_timeout |-> $past(acc && bus_cmd_op == 2'd3));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    poll_done |=> !poll_done);

  p_status_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    poll_done |-> (poll_ok ^ poll_timeout));

  p_status_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !poll_done |-> !poll_ok && !poll_timeout);

  p_idle_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    poll_done |-> !bus_cmd_valid);
endmodule

bind ackpoll_master ackpoll_master_chk #(
  .MAX_TRIES    (MAX_TRIES),
  .STOP_BETWEEN (STOP_BETWEEN)
) chk_i (.*);

// File: tb/ackpoll_master_tb_lane.sv
module ackpoll_master_tb_lane #(
  parameter bit STOPB = 1'b0,
  parameter int MAXT  = 4
) (
  input logic clk
);
  localparam int CW = $clog2(MAXT + 1);

  logic          rst, poll_req, write_busy, next_rw, bus_cmd_ready, bus_ack;
  logic [6:0]    dev_sel;
  logic          poll_done, poll_ok, poll_timeout, bus_cmd_valid;
  logic [CW-1:0] attempt_cnt;
  logic [1:0]    bus_cmd_op;
  logic [7:0]    bus_cmd_byte;

  ackpoll_master #(.MAX_TRIES(MAXT), .STOP_BETWEEN(STOPB)) dut_i (
    .clk(clk), .rst(rst), .poll_req(poll_req), .write_busy(write_busy),
    .dev_sel(dev_sel), .next_rw(next_rw), .poll_done(poll_done), .poll_ok(poll_ok),
    .poll_timeout(poll_timeout), .attempt_cnt(attempt_cnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd_op(bus_cmd_op), .bus_cmd_byte(bus_cmd_byte), .bus_cmd_ready(bus_cmd_ready),
    .bus_ack(bus_ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // stimulus settings
  bit s_rst = 1, s_req = 0, s_busy = 0, s_rw = 0, s_stall = 0;
  logic [6:0] s_sel = '0;
  int s_polls = 0;
  int cyc = 0;

  // reference model
  int q[$];
  bit m_active = 0, m_pend_to = 0, m_done = 0, m_ok = 0, m_to = 0;
  int m_cnt = 0, m_byte = 0, acks_seen = 0;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s (lane stop=%0d): actual %0d expected %0d", req, STOPB, act, exp);
    end
  endtask

  task automatic push_probe();
    q.push_back(0 << 8);
    q.push_back((1 << 8) | m_byte);
    q.push_back(2 << 8);
  endtask

  task automatic tick();
    int f;
    @(negedge clk);
    chk(bus_cmd_valid == (q.size() > 0), "R9 cmd_valid", int'(bus_cmd_valid), int'(q.size() > 0));
    if (q.size() > 0 && bus_cmd_valid) begin
      chk(int'(bus_cmd_op) == (q[0] >> 8), "R3 R4 R7 op order", int'(bus_cmd_op), q[0] >> 8);
      if ((q[0] >> 8) == 1)
        chk(int'(bus_cmd_byte) == (q[0] & 255), "R3 select byte", int'(bus_cmd_byte), q[0] & 255);
    end
    chk(poll_done == m_done, "R8 done pulse", int'(poll_done), int'(m_done));
    chk(poll_ok == m_ok, "R5 ok status", int'(poll_ok), int'(m_ok));
    chk(poll_timeout == m_to, "R7 timeout status", int'(poll_timeout), int'(m_to));
    chk(int'(attempt_cnt) == m_cnt, "R6 attempt count", int'(attempt_cnt), m_cnt);
    // drive inputs for the coming edge
    cyc++;
    rst           = s_rst;
    poll_req      = s_req;
    write_busy    = s_busy;
    dev_sel       = s_sel;
    next_rw       = s_rw;
    bus_cmd_ready = s_stall ? (cyc % 3 != 0) : 1'b1;
    bus_ack       = (acks_seen >= s_polls);
    // model the coming edge
    m_done = 0; m_ok = 0; m_to = 0;
    if (s_rst) begin
      q.delete();
      m_active = 0; m_pend_to = 0; m_cnt = 0;
    end else if (!m_active) begin
      if (s_req && s_busy) begin
        m_active = 1;
        m_cnt = 0;
        m_byte = {s_sel, s_rw};
        push_probe();
      end
    end else if (bus_cmd_ready && q.size() > 0) begin
      f = q.pop_front();
      if ((f >> 8) == 2) begin
        m_cnt++;
        if (bus_ack) begin
          m_done = 1; m_ok = 1; m_active = 0;
        end else if (m_cnt == MAXT) begin
          q.push_back(3 << 8);
          m_pend_to = 1;
        end else begin
          if (STOPB) q.push_back(3 << 8);
          push_probe();
        end
        acks_seen++;
      end else if ((f >> 8) == 3 && m_pend_to) begin
        m_done = 1; m_to = 1; m_active = 0; m_pend_to = 0;
      end
    end
  endtask

  task automatic run_poll(input logic [6:0] sel, input bit rw, input int polls,
                          input bit stall, input int hold);
    s_sel = sel; s_rw = rw; s_polls = polls; s_stall = stall;
    s_busy = 1; s_req = 1; acks_seen = 0;
    repeat (hold) tick();
    s_req = 0;
    for (int i = 0; i < 300 && m_active; i++) tick();
    repeat (2) tick();
  endtask

  initial begin
    rst = 1; poll_req = 0; write_busy = 0; dev_sel = '0; next_rw = 0;
    bus_cmd_ready = 0; bus_ack = 0;
    repeat (3) tick();
    // R1: quiet state after reset
    chk(!bus_cmd_valid && !poll_done && attempt_cnt == '0, "R1 reset state",
        int'(bus_cmd_valid) + int'(poll_done) + int'(attempt_cnt), 0);
    s_rst = 0;
    tick();
    // R2: request without a pending write is ignored
    s_busy = 0; s_req = 1;
    repeat (4) tick();
    s_req = 0;
    tick();
    chk(!bus_cmd_valid && attempt_cnt == '0, "R2 ignored without write",
        int'(bus_cmd_valid), 0);
    // R5: target answers at once
    run_poll(7'h50, 1'b0, 0, 1'b0, 1);
    // R3 R4: a few busy probes, stalling bus, request held high (R2)
    run_poll(7'h2A, 1'b1, 3, 1'b1, 5);
    // boundary: answers on the last allowed probe
    run_poll(7'h71, 1'b0, MAXT - 1, 1'b0, 1);
    chk(int'(attempt_cnt) == MAXT, "R6 count on last probe", int'(attempt_cnt), MAXT);
    // R7: never answers
    run_poll(7'h13, 1'b1, MAXT + 5, 1'b1, 1);
    chk(int'(attempt_cnt) == MAXT, "R7 count at timeout", int'(attempt_cnt), MAXT);
    // R6: new request restarts the count
    run_poll(7'h66, 1'b0, 1, 1'b0, 1);
    chk(int'(attempt_cnt) == 2, "R6 cleared and recounted", int'(attempt_cnt), 2);
    finished = 1;
  end
endmodule

// File: tb/ackpoll_master_tb_top.sv
module ackpoll_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  ackpoll_master_tb_lane #(.STOPB(1'b0), .MAXT(4)) lane_direct (.clk(clk));
  ackpoll_master_tb_lane #(.STOPB(1'b1), .MAXT(4)) lane_stop (.clk(clk));

  initial begin
    int total;
    int failed;
    int waited;
    waited = 0;
    while (!(lane_direct.finished && lane_stop.finished) && waited < WATCHDOG_CYCLES) begin
      @(posedge clk);
      waited++;
    end
    total  = lane_direct.n_chk + lane_stop.n_chk;
    failed = lane_direct.n_fail + lane_stop.n_fail;
    if (waited >= WATCHDOG_CYCLES) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", waited, WATCHDOG_CYCLES);
    end
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule